// File: doc/BRIEF.md
# Bus Control-Word Dictionary Encoder

This block sits beside a shared system bus as part of a trace path. Five control fields stay constant for the whole of a transfer: direction, burst type, beat size, protection attributes and the granted master's number. The block packs these fields into a single 15-bit control word. It takes that word once, in the cycle a transfer is started and accepted, and not again during burst continuation beats. The word is then turned into a short token for a downstream trace packer.

The block keeps a small content-addressed dictionary of recently seen control words. When the word is already in the dictionary, the token carries only a hit flag and the 3-bit slot number. Otherwise the token carries the full 15-bit literal and the slot into which the word is now being learned. Slots are filled and overwritten in strict cyclic order. A decoder that mirrors the same pointer can therefore rebuild the dictionary from the token stream alone.

The token leaves as a valid-only stream. A passive bus observer cannot stall the bus, so there is no ready input and no back-pressure. A consumer must accept a token in the cycle its valid strobe is high, because the token is gone in the next cycle.

Top module: `ctl_dict_encoder`

## Requirements
- R1: While `rst_n` is low, and after it is released, `tok_valid` is 0 and every dictionary slot is empty. The first transfer after reset therefore always misses and is stored in slot 0.
- R2: A transfer start is a cycle with `bus_trans` = 2'b10 (non-sequential) and `bus_ready` = 1. Each start produces exactly one token, with `tok_valid` high for one cycle, in the cycle after the start's clock edge.
- R3: Cycles with `bus_trans` equal to 2'b00 (idle), 2'b01 (busy) or 2'b11 (sequential), or with `bus_ready` = 0, produce no token. They also leave the dictionary and the replacement pointer unchanged.
- R4: The control word is {`bus_master`[3:0], `bus_prot`[3:0], `bus_size`[2:0], `bus_burst`[2:0], `bus_write`}, with `bus_write` in bit 0 and `bus_master` in bits 14:11. On a miss, `tok_hit` = 0 and `tok_literal` equals this word.
- R5: On a hit, `tok_hit` = 1, `tok_index` is the slot holding the word, and `tok_literal` is 0.
- R6: On a miss, the word is written into the slot named by a replacement pointer, and `tok_index` reports that slot. The pointer starts at 0 after reset and advances by one on every miss.
- R7: After the eighth miss the pointer wraps. The ninth distinct word overwrites slot 0, the next miss overwrites slot 1, and an evicted word misses when it returns.
- R8: A word learned at one start is found as a hit by a start in the very next cycle.
- R9: If more than one valid slot matches, the lowest slot number is reported. In normal operation no two valid slots hold the same word.
- R10: While `tok_valid` is 0, `tok_hit`, `tok_index` and `tok_literal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_write | input | 1 | Transfer direction, 1 = write |
| bus_burst | input | 3 | Burst type |
| bus_size | input | 3 | Beat size code |
| bus_prot | input | 4 | Protection attributes |
| bus_master | input | 4 | Number of the granted master |
| bus_trans | input | 2 | Transfer type: 00 idle, 01 busy, 10 non-sequential, 11 sequential |
| bus_ready | input | 1 | Previous transfer completes; the current address phase is accepted |
| tok_valid | output | 1 | Token strobe, one cycle per transfer start |
| tok_hit | output | 1 | 1 = dictionary hit, 0 = literal |
| tok_index | output | 3 | Slot that hit, or slot being learned on a miss |
| tok_literal | output | 15 | Full control word on a miss, 0 on a hit |

## Verification
The embedded properties assume that the transfer-type input always carries one of its four defined codes. They also assume that reset is asserted long enough to clear every slot before the first start, so that no two valid slots can hold the same word. The stimulus keeps to this: it asserts reset for several cycles at the start and before each directed sequence, and changes inputs only on falling edges. Non-starting cycles vary the transfer type and the ready signal while offering words that have not yet been learned. A later miss at the expected slot then shows that those cycles altered neither the dictionary nor the pointer.

// File: rtl/ctl_dict_pkg.sv
package ctl_dict_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } xfer_kind_e;

  localparam int unsigned DEF_MST_W   = 4;
  localparam int unsigned DEF_PROT_W  = 4;
  localparam int unsigned DEF_SIZE_W  = 3;
  localparam int unsigned DEF_BURST_W = 3;
  localparam int unsigned DEF_DEPTH   = 8;

endpackage

// File: rtl/ctl_xfer_start.sv
module ctl_xfer_start
  import ctl_dict_pkg::*;
#(
  parameter int unsigned MST_W   = DEF_MST_W,
  parameter int unsigned PROT_W  = DEF_PROT_W,
  parameter int unsigned SIZE_W  = DEF_SIZE_W,
  parameter int unsigned BURST_W = DEF_BURST_W,
  localparam int unsigned WORD_W = MST_W + PROT_W + SIZE_W + BURST_W + 1
) (
  input  logic               bus_write,
  input  logic [BURST_W-1:0] bus_burst,
  input  logic [SIZE_W-1:0]  bus_size,
  input  logic [PROT_W-1:0]  bus_prot,
  input  logic [MST_W-1:0]   bus_master,
  input  logic [1:0]         bus_trans,
  input  logic               bus_ready,
  output logic               start,
  output logic [WORD_W-1:0]  word
);

  // Only the accepted first beat of a transfer opens a lookup; burst
  // continuation, idle and busy beats are ignored.
  always_comb begin
    start = (bus_trans == TR_NONSEQ) && bus_ready;
  end

  // Field order is fixed: the decoder on the host side relies on it.
  always_comb begin
    word = {bus_master, bus_prot, bus_size, bus_burst, bus_write};
  end

endmodule

// File: rtl/ctl_cam_dict.sv
module ctl_cam_dict
  import ctl_dict_pkg::*;
#(
  parameter int unsigned WORD_W = 15,
  parameter int unsigned DEPTH  = DEF_DEPTH,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookup_en,
  input  logic [WORD_W-1:0] key,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [IDX_W-1:0]  wr_ptr
);

  logic [WORD_W-1:0] entry_word [DEPTH];
  logic [DEPTH-1:0]  entry_vld;
  logic [DEPTH-1:0]  match_vec;
  logic              learn;

  assign learn = lookup_en && !hit;

  // Storage and comparators, one set per slot.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_word[g] <= '0;
        entry_vld[g]  <= 1'b0;
      end else if (learn && (wr_ptr == IDX_W'(g))) begin
        entry_word[g] <= key;
        entry_vld[g]  <= 1'b1;
      end
    end

    assign match_vec[g] = entry_vld[g] && (entry_word[g] == key);
  end

  // Priority resolve: scanning downward leaves the lowest matching slot.
  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |match_vec;

  // Cyclic replacement pointer; DEPTH is a power of two so it wraps.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
    end else if (learn) begin
      wr_ptr <= wr_ptr + 1'b1;
    end
  end

  AST_NO_DUP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R9

  AST_PTR_STEP_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_en && !hit) |=> (wr_ptr == $past(wr_ptr) + 1'b1)); // R6

  AST_PTR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_en |=> $stable(wr_ptr)); // R3

  AST_DICT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_en |=> $stable(entry_vld)); // R3

  AST_LEARNED_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_en && !hit) |=> entry_vld[$past(wr_ptr)]); // R6

endmodule

// File: rtl/ctl_token_reg.sv
module ctl_token_reg #(
  parameter int unsigned WORD_W = 15,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hit,
  input  logic [IDX_W-1:0]  hit_idx,
  input  logic [IDX_W-1:0]  wr_ptr,
  input  logic [WORD_W-1:0] word,
  output logic              tok_valid,
  output logic              tok_hit,
  output logic [IDX_W-1:0]  tok_index,
  output logic [WORD_W-1:0] tok_literal
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_valid   <= 1'b0;
      tok_hit     <= 1'b0;
      tok_index   <= '0;
      tok_literal <= '0;
    end else if (start) begin
      tok_valid   <= 1'b1;
      tok_hit     <= hit;
      tok_index   <= hit ? hit_idx : wr_ptr;
      tok_literal <= hit ? '0 : word;
    end else begin
      tok_valid   <= 1'b0;
      tok_hit     <= 1'b0;
      tok_index   <= '0;
      tok_literal <= '0;
    end
  end

  AST_TOKEN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> tok_valid); // R2

  AST_NO_TOKEN_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !tok_valid); // R3

  AST_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |-> (!tok_hit && (tok_index == '0) && (tok_literal == '0))); // R10

  AST_HIT_NO_LITERAL: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_hit) |-> (tok_literal == '0)); // R5

endmodule

// File: rtl/ctl_dict_encoder.sv
module ctl_dict_encoder
  import ctl_dict_pkg::*;
#(
  parameter int unsigned MST_W   = DEF_MST_W,
  parameter int unsigned PROT_W  = DEF_PROT_W,
  parameter int unsigned SIZE_W  = DEF_SIZE_W,
  parameter int unsigned BURST_W = DEF_BURST_W,
  parameter int unsigned DEPTH   = DEF_DEPTH,
  localparam int unsigned WORD_W = MST_W + PROT_W + SIZE_W + BURST_W + 1,
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_write,
  input  logic [BURST_W-1:0] bus_burst,
  input  logic [SIZE_W-1:0]  bus_size,
  input  logic [PROT_W-1:0]  bus_prot,
  input  logic [MST_W-1:0]   bus_master,
  input  logic [1:0]         bus_trans,
  input  logic               bus_ready,
  output logic               tok_valid,
  output logic               tok_hit,
  output logic [IDX_W-1:0]   tok_index,
  output logic [WORD_W-1:0]  tok_literal
);

  logic              start;
  logic [WORD_W-1:0] word;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [IDX_W-1:0]  wr_ptr;

  ctl_xfer_start #(
    .MST_W  (MST_W),
    .PROT_W (PROT_W),
    .SIZE_W (SIZE_W),
    .BURST_W(BURST_W)
  ) u_start (
    .bus_write (bus_write),
    .bus_burst (bus_burst),
    .bus_size  (bus_size),
    .bus_prot  (bus_prot),
    .bus_master(bus_master),
    .bus_trans (bus_trans),
    .bus_ready (bus_ready),
    .start     (start),
    .word      (word)
  );

  ctl_cam_dict #(
    .WORD_W(WORD_W),
    .DEPTH (DEPTH)
  ) u_cam (
    .clk      (clk),
    .rst_n    (rst_n),
    .lookup_en(start),
    .key      (word),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .wr_ptr   (wr_ptr)
  );

  ctl_token_reg #(
    .WORD_W(WORD_W),
    .IDX_W (IDX_W)
  ) u_tok (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .hit        (hit),
    .hit_idx    (hit_idx),
    .wr_ptr     (wr_ptr),
    .word       (word),
    .tok_valid  (tok_valid),
    .tok_hit    (tok_hit),
    .tok_index  (tok_index),
    .tok_literal(tok_literal)
  );

  AST_TOKEN_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |-> $past(bus_ready && (bus_trans == TR_NONSEQ))); // R2

  AST_MISS_CARRIES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !tok_hit) |->
      (tok_literal == $past({bus_master, bus_prot, bus_size, bus_burst, bus_write}))); // R4

endmodule

// File: tb/ctl_dict_encoder_tb_top.sv
`timescale 1ns/1ps
module ctl_dict_encoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_burst = '0;
  logic [2:0]  bus_size = '0;
  logic [3:0]  bus_prot = '0;
  logic [3:0]  bus_master = '0;
  logic [1:0]  bus_trans = 2'b00;
  logic        bus_ready = 1'b0;
  logic        tok_valid;
  logic        tok_hit;
  logic [2:0]  tok_index;
  logic [14:0] tok_literal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ctl_dict_encoder dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_write(bus_write), .bus_burst(bus_burst), .bus_size(bus_size),
    .bus_prot(bus_prot), .bus_master(bus_master),
    .bus_trans(bus_trans), .bus_ready(bus_ready),
    .tok_valid(tok_valid), .tok_hit(tok_hit),
    .tok_index(tok_index), .tok_literal(tok_literal)
  );

  typedef struct packed {
    logic [1:0] tr;
    logic       rdy;
    logic [3:0] m;
    logic [3:0] p;
    logic [2:0] s;
    logic [2:0] b;
    logic       w;
    logic       ev;
    logic       eh;
    logic [2:0] ei;
  } vec_t;

  // Words: A = m1 p3 s2 b0 w1, B = m2 p3 s2 b1 w0, C = m15 p0 s0 b7 w1.
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'b10, 1'b1, 4'd1,  4'd3, 3'd2, 3'd0, 1'b1, 1'b1, 1'b0, 3'd0}, // A miss -> 0
    '{2'b11, 1'b1, 4'd1,  4'd3, 3'd2, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0}, // SEQ none
    '{2'b10, 1'b1, 4'd2,  4'd3, 3'd2, 3'd1, 1'b0, 1'b1, 1'b0, 3'd1}, // B miss -> 1
    '{2'b10, 1'b1, 4'd1,  4'd3, 3'd2, 3'd0, 1'b1, 1'b1, 1'b1, 3'd0}, // A hit 0
    '{2'b00, 1'b1, 4'd15, 4'd0, 3'd0, 3'd7, 1'b1, 1'b0, 1'b0, 3'd0}, // IDLE none
    '{2'b10, 1'b0, 4'd15, 4'd0, 3'd0, 3'd7, 1'b1, 1'b0, 1'b0, 3'd0}, // not ready
    '{2'b10, 1'b1, 4'd15, 4'd0, 3'd0, 3'd7, 1'b1, 1'b1, 1'b0, 3'd2}, // C miss -> 2
    '{2'b01, 1'b1, 4'd15, 4'd0, 3'd0, 3'd7, 1'b1, 1'b0, 1'b0, 3'd0}, // BUSY none
    '{2'b10, 1'b1, 4'd2,  4'd3, 3'd2, 3'd1, 1'b0, 1'b1, 1'b1, 3'd1}, // B hit 1
    '{2'b10, 1'b1, 4'd15, 4'd0, 3'd0, 3'd7, 1'b1, 1'b1, 1'b1, 3'd2}  // C hit 2
  };

  function automatic logic [14:0] pack_word(logic [3:0] m, logic [3:0] p,
                                            logic [2:0] s, logic [2:0] b, logic w);
    logic [14:0] r;
    r[0]     = w;
    r[3:1]   = b;
    r[6:4]   = s;
    r[10:7]  = p;
    r[14:11] = m;
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] tr, logic rdy, logic [14:0] wd);
    bus_trans  = tr;
    bus_ready  = rdy;
    bus_write  = wd[0];
    bus_burst  = wd[3:1];
    bus_size   = wd[6:4];
    bus_prot   = wd[10:7];
    bus_master = wd[14:11];
    @(negedge clk);
  endtask

  task automatic expect_tok(string req, logic v, logic h, logic [2:0] idx, logic [14:0] lit);
    check({req, " valid"}, 32'(tok_valid), 32'(v));
    check({req, " hit"}, 32'(tok_hit), 32'(h));
    check({req, " index"}, 32'(tok_index), 32'(idx));
    check({req, " literal"}, 32'(tok_literal), 32'(lit));
  endtask

  task automatic do_reset();
    @(negedge clk);
    bus_trans = 2'b00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    expect_tok("R1 in reset", 1'b0, 1'b0, 3'd0, 15'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [14:0] fill_word(int k);
    return pack_word(4'(k), 4'hA, 3'd1, 3'd2, 1'b0);
  endfunction

  initial begin
    logic [14:0] wd;
    logic [14:0] wd_d;
    do_reset();
    expect_tok("R1 after reset", 1'b0, 1'b0, 3'd0, 15'd0);

    // Table walk: R2 R3 R4 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      wd = pack_word(VEC[i].m, VEC[i].p, VEC[i].s, VEC[i].b, VEC[i].w);
      drive(VEC[i].tr, VEC[i].rdy, wd);
      if (!VEC[i].ev)
        expect_tok($sformatf("R3/R10 vec%0d", i), 1'b0, 1'b0, 3'd0, 15'd0);
      else if (VEC[i].eh)
        expect_tok($sformatf("R5 vec%0d", i), 1'b1, 1'b1, VEC[i].ei, 15'd0);
      else
        expect_tok($sformatf("R4/R6 vec%0d", i), 1'b1, 1'b0, VEC[i].ei, wd);
    end
    // R2: token lasts only one cycle
    drive(2'b00, 1'b1, 15'd0);
    check("R2 single-cycle token", 32'(tok_valid), 32'd0);

    // R4 field placement: only master bits set
    wd = pack_word(4'h9, 4'h0, 3'd0, 3'd0, 1'b0);
    drive(2'b10, 1'b1, wd);
    expect_tok("R4 master field", 1'b1, 1'b0, 3'd3, 15'h4800);

    // R1: reset clears the dictionary; A misses into slot 0 again
    do_reset();
    wd = pack_word(4'd1, 4'd3, 3'd2, 3'd0, 1'b1);
    drive(2'b10, 1'b1, wd);
    expect_tok("R1 empty after reset", 1'b1, 1'b0, 3'd0, wd);

    // R3: SEQ with a new word does not learn it
    wd_d = pack_word(4'd7, 4'd7, 3'd7, 3'd7, 1'b1);
    drive(2'b11, 1'b1, wd_d);
    check("R3 seq no token", 32'(tok_valid), 32'd0);
    // R8: back-to-back miss then hit of the same word
    drive(2'b10, 1'b1, wd_d);
    expect_tok("R8 learn", 1'b1, 1'b0, 3'd1, wd_d);
    drive(2'b10, 1'b1, wd_d);
    expect_tok("R8 next-cycle hit", 1'b1, 1'b1, 3'd1, 15'd0);

    // R7: fill all slots, then wrap
    do_reset();
    for (int k = 0; k < 8; k++) begin
      drive(2'b10, 1'b1, fill_word(k));
      expect_tok($sformatf("R6 fill %0d", k), 1'b1, 1'b0, 3'(k), fill_word(k));
    end
    for (int k = 0; k < 8; k++) begin
      drive(2'b10, 1'b1, fill_word(k));
      expect_tok($sformatf("R5 refetch %0d", k), 1'b1, 1'b1, 3'(k), 15'd0);
    end
    drive(2'b10, 1'b1, fill_word(8));
    expect_tok("R7 ninth word into slot 0", 1'b1, 1'b0, 3'd0, fill_word(8));
    drive(2'b10, 1'b1, fill_word(0));
    expect_tok("R7 evicted word misses into slot 1", 1'b1, 1'b0, 3'd1, fill_word(0));
    drive(2'b10, 1'b1, fill_word(2));
    expect_tok("R7 untouched slot still hits", 1'b1, 1'b1, 3'd2, 15'd0);
    drive(2'b10, 1'b1, fill_word(1));
    expect_tok("R7 second eviction into slot 2", 1'b1, 1'b0, 3'd2, fill_word(1));
    drive(2'b10, 1'b1, fill_word(8));
    expect_tok("R9 single match for wrapped word", 1'b1, 1'b1, 3'd0, 15'd0);

    drive(2'b00, 1'b0, 15'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule